// File: doc/BRIEF.md
# Manchester Block-Framed Serial Transmitter

The block turns one frame of block-organised measurement data into a single Manchester-coded serial line. A one-cycle start pulse captures a block count and fifteen 128-bit data blocks. The frame then goes out as a 16-bit start word, followed by each captured block. A block is sent as eight 16-bit words and then its own 16-bit check word. A busy flag covers the whole frame. Start pulses that arrive while a frame is on the line are dropped.

Bit timing comes from a single parameter, the number of clock cycles in each half-bit. At 100 MHz and the default of two cycles per half-bit, the longest frame (15 blocks, 2176 bits) takes about 87 us. It therefore fits inside the usual 100 us spacing of start pulses. The line rests low whenever no frame is being sent.

Top module: `mbt_frame_tx`

## Requirements
- R1: A start pulse seen while idle captures the block count and every block input, and busy_o is high from the following cycle.
- R2: A start pulse seen while busy_o is high is ignored, and the frame already in flight keeps its captured count and data.
- R3: line_o is low in every cycle in which busy_o is low.
- R4: Each frame opens with the word 0x0564.
- R5: A frame holds N blocks, where N is the block count input, a count of 0 is sent as 1 block, and busy_o stays high for exactly (16 + 144*N) * 2 * HALF_CYC cycles.
- R6: Within a block, words go out in the order R0 to R7, where word Rn is taken from bits [16n+15:16n] of that block's 128-bit input slice. Block k (counting from 0) occupies bits [128k+127:128k] of blk_data_i, and every word is sent most significant bit first.
- R7: After the eight words of each block comes a check word, also sent MSB first. It is computed MSB first over those eight words only, with polynomial 0x3D65 and initial value 0x0000, and the result is bitwise inverted.
- R8: Each bit lasts 2*HALF_CYC cycles. A 1 is sent high for the first half and low for the second, and a 0 is sent low and then high.
- R9: busy_o falls in the cycle after the last half-bit of the final check word, and a start pulse in that very cycle begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-frame pulse |
| blk_cnt_i | input | 4 | Number of blocks to send (0 is sent as 1) |
| blk_data_i | input | 1920 | Fifteen 128-bit blocks, block k in bits [128k+127:128k] |
| line_o | output | 1 | Manchester-coded serial line |
| busy_o | output | 1 | High while a frame is being sent |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- An all-zero single block must carry check word 0xFFFF. A missing inversion or a non-zero seed shows up at once.
- A count of zero must still send one block. A design that skips the clamp would send an empty or 16-block frame and get the busy length wrong.
- A start pulse with different data in the middle of a 15-block frame must change nothing. A design that re-latches would corrupt the tail of that frame.
- Frames started in the very cycle busy_o falls must come out whole. A check word that leaked across block boundaries or frames would fail against the bench's own CRC.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  localparam int unsigned WORD_W        = 16;
  localparam int unsigned WORDS_PER_BLK = 8;
  localparam int unsigned BLK_BITS      = WORD_W * WORDS_PER_BLK;
  localparam logic [15:0] SYNC_WORD     = 16'h0564;
  localparam logic [15:0] CRC_POLY      = 16'h3D65;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_SYNC,
    WK_DATA,
    WK_CRC
  } word_kind_e;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/mbt_half_timer.sv
module mbt_half_timer #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic run_i,
  output logic half_o,
  output logic bit_end_o
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] hcnt_q;
  logic          half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      half_q <= 1'b0;
    end else if (go_i) begin
      hcnt_q <= '0;
      half_q <= 1'b0;
    end else if (run_i) begin
      if (hcnt_q == LAST) begin
        hcnt_q <= '0;
        half_q <= ~half_q;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assign half_o    = half_q;
  assign bit_end_o = run_i & half_q & (hcnt_q == LAST);

  p_hcnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q <= LAST);
  p_half_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !go_i && hcnt_q != LAST) |=> $stable(half_q));
endmodule

// File: rtl/mbt_crc16.sv
module mbt_crc16
  import mbt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc_step(crc_q, bit_i);
  end

  assign crc_o = crc_q;

  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(crc_q));
endmodule

// File: rtl/mbt_word_seq.sv
module mbt_word_seq
  import mbt_pkg::*;
#(
  parameter int unsigned MAX_BLK = 15,
  localparam int unsigned BW     = $clog2(MAX_BLK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          adv_i,
  input  logic [BW-1:0] last_blk_i,
  output word_kind_e    kind_o,
  output logic [BW-1:0] blk_o,
  output logic [2:0]    word_o,
  output logic [3:0]    bit_o,
  output logic          frame_end_o
);
  word_kind_e    kind_q;
  logic [BW-1:0] blk_q;
  logic [2:0]    word_q;
  logic [3:0]    bit_q;
  logic          word_end;

  assign word_end    = adv_i & (bit_q == 4'd0);
  assign frame_end_o = word_end & (kind_q == WK_CRC) & (blk_q == last_blk_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= WK_IDLE;
      blk_q  <= '0;
      word_q <= '0;
      bit_q  <= 4'd15;
    end else if (go_i) begin
      kind_q <= WK_SYNC;
      blk_q  <= '0;
      word_q <= '0;
      bit_q  <= 4'd15;
    end else if (adv_i) begin
      bit_q <= bit_q - 4'd1;
      if (word_end) begin
        bit_q <= 4'd15;
        case (kind_q)
          WK_SYNC: begin
            kind_q <= WK_DATA;
            word_q <= '0;
          end
          WK_DATA: begin
            if (word_q == 3'(WORDS_PER_BLK - 1)) kind_q <= WK_CRC;
            else                                 word_q <= word_q + 3'd1;
          end
          WK_CRC: begin
            if (blk_q == last_blk_i) begin
              kind_q <= WK_IDLE;
            end else begin
              kind_q <= WK_DATA;
              blk_q  <= blk_q + 1'b1;
              word_q <= '0;
            end
          end
          default: kind_q <= WK_IDLE;
        endcase
      end
    end
  end

  assign kind_o = kind_q;
  assign blk_o  = blk_q;
  assign word_o = word_q;
  assign bit_o  = bit_q;

  p_sync_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> (kind_q == WK_SYNC && bit_q == 4'd15));
  p_blk_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q != WK_IDLE) |-> (blk_q <= last_blk_i));
  p_crc_after_r7_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_end && kind_q == WK_DATA && word_q == 3'd7) |=> kind_q == WK_CRC);
endmodule

// File: rtl/mbt_frame_tx.sv
module mbt_frame_tx
  import mbt_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2,
  parameter int unsigned MAX_BLK  = 15,
  localparam int unsigned CW      = $clog2(MAX_BLK + 1),
  localparam int unsigned BW      = $clog2(MAX_BLK)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [CW-1:0]               blk_cnt_i,
  input  logic [MAX_BLK*BLK_BITS-1:0] blk_data_i,
  output logic                        line_o,
  output logic                        busy_o
);
  logic                busy_q;
  logic [BW-1:0]       last_q;
  logic [BLK_BITS-1:0] data_q [MAX_BLK];

  logic          go;
  logic [CW-1:0] cnt_eff;
  logic          half, bit_end, frame_end;
  word_kind_e    kind;
  logic [BW-1:0] blk;
  logic [2:0]    word;
  logic [3:0]    bit_idx;
  logic [15:0]   crc;
  logic [15:0]   cur_word;
  logic          cur_bit;

  assign go = start_i & ~busy_q;

  always_comb begin
    if (blk_cnt_i == '0)                      cnt_eff = CW'(1);
    else if (blk_cnt_i > CW'(MAX_BLK))        cnt_eff = CW'(MAX_BLK);
    else                                      cnt_eff = blk_cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      last_q <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      last_q <= BW'(cnt_eff - CW'(1));
    end else if (frame_end) begin
      busy_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < MAX_BLK; g++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  data_q[g] <= '0;
      else if (go)  data_q[g] <= blk_data_i[g*BLK_BITS +: BLK_BITS];
    end
  end

  mbt_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .run_i     (busy_q),
    .half_o    (half),
    .bit_end_o (bit_end)
  );

  mbt_word_seq #(.MAX_BLK(MAX_BLK)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .adv_i       (bit_end),
    .last_blk_i  (last_q),
    .kind_o      (kind),
    .blk_o       (blk),
    .word_o      (word),
    .bit_o       (bit_idx),
    .frame_end_o (frame_end)
  );

  always_comb begin
    case (kind)
      WK_SYNC: cur_word = SYNC_WORD;
      WK_DATA: cur_word = data_q[blk][{word, 4'b0000} +: WORD_W];
      WK_CRC:  cur_word = ~crc;
      default: cur_word = '0;
    endcase
  end

  assign cur_bit = cur_word[bit_idx];

  mbt_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (go | (bit_end & (kind == WK_CRC) & (bit_idx == 4'd0))),
    .en_i   (bit_end & (kind == WK_DATA)),
    .bit_i  (cur_bit),
    .crc_o  (crc)
  );

  // first half carries the bit value, second half its complement
  assign line_o = busy_q & (cur_bit ^ half);
  assign busy_o = busy_q;

  p_start_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> busy_q);
  p_ignore_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(last_q));
  p_idle_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !line_o);
  p_mid_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $rose(half)) |-> (line_o != $past(line_o)));
  p_crc_fresh_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == WK_DATA && word == 3'd0 && bit_idx == 4'd15) |-> (crc == 16'h0000));
  p_busy_kind_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q == (kind != WK_IDLE));
endmodule

// File: tb/mbt_frame_tx_bench.sv
module mbt_frame_tx_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned HALF       = 3;
  localparam int unsigned NBLK       = 15;
  localparam int unsigned MAXBITS    = 16 + 144 * NBLK;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start = 1'b0;
  logic [3:0]            cnt = '0;
  logic [NBLK*128-1:0]   din = '0;
  logic                  line, busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic exp_bit [MAXBITS];
  int   exp_reg [MAXBITS];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbt_frame_tx #(.HALF_CYC(HALF), .MAX_BLK(NBLK)) u_mbt_frame_tx (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .blk_cnt_i  (cnt),
    .blk_data_i (din),
    .line_o     (line),
    .busy_o     (busy)
  );

  function automatic logic [15:0] ref_crc(input logic [127:0] blk);
    logic [15:0] c = 16'h0000;
    for (int w = 0; w < 8; w++)
      for (int b = 15; b >= 0; b--) begin
        logic fb = c[15] ^ blk[16*w + b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h3D65;
      end
    return ~c;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic build(input int n, input logic [NBLK*128-1:0] d, output int nb);
    int k = 0;
    for (int b = 15; b >= 0; b--) begin exp_bit[k] = 1'(16'h0564 >> b); exp_reg[k] = 0; k++; end
    for (int blk = 0; blk < n; blk++) begin
      logic [127:0] s = d[blk*128 +: 128];
      logic [15:0]  c = ref_crc(s);
      for (int w = 0; w < 8; w++)
        for (int b = 15; b >= 0; b--) begin exp_bit[k] = s[16*w + b]; exp_reg[k] = 1; k++; end
      for (int b = 15; b >= 0; b--) begin exp_bit[k] = c[b]; exp_reg[k] = 2; k++; end
    end
    nb = k;
  endtask

  // Called at a negedge with busy low; returns at the negedge after the frame.
  task automatic run_frame(input logic [3:0] c, input int ignore_at);
    int n, nb, total, e_sync, e_data, e_crc, e_all, busy_lo;
    logic [NBLK*128-1:0] snap = din;
    n = (c == 0) ? 1 : ((c > NBLK) ? NBLK : int'(c));
    build(n, snap, nb);
    total = nb * 2 * HALF;
    e_sync = 0; e_data = 0; e_crc = 0; e_all = 0; busy_lo = 0;
    check("R9", "busy before start", busy, 0);
    cnt = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1", "busy after start", busy, 1);
    for (int cyc = 0; cyc < total; cyc++) begin
      int k = cyc / (2 * HALF);
      int h = (cyc / HALF) % 2;
      logic ex = exp_bit[k] ^ logic'(h);
      if (busy !== 1'b1) busy_lo++;
      if (line !== ex) begin
        e_all++;
        if (exp_reg[k] == 0) e_sync++;
        else if (exp_reg[k] == 1) e_data++;
        else e_crc++;
      end
      if (cyc == ignore_at) begin start = 1'b1; cnt = 4'd3; din = ~snap; end
      if (cyc == ignore_at + 1) start = 1'b0;
      @(negedge clk);
    end
    check("R4", "sync word mismatches", e_sync, 0);
    check("R6", "data word mismatches", e_data, 0);
    check("R7", "crc word mismatches", e_crc, 0);
    check("R8", "manchester line mismatches", e_all, 0);
    if (ignore_at >= 0) check("R2", "line mismatches with ignored start", e_all, 0);
    check("R5", "busy low inside frame", busy_lo, 0);
    check("R5", "busy after frame length", busy, 0);
    check("R3", "line idle after frame", line, 0);
  endtask

  task automatic rand_din();
    for (int i = 0; i < NBLK * 4; i++) din[i*32 +: 32] = $urandom;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    check("R3", "reset line", line, 0);
    check("R1", "reset busy", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R3", "idle line", line, 0);

    din = '0;                       // all-zero block: check word 0xFFFF
    run_frame(4'd1, -1);
    repeat (3) @(negedge clk);
    check("R3", "gap line low", line, 0);

    rand_din();                     // count 0 sends one block
    run_frame(4'd0, -1);
    @(negedge clk);

    rand_din();                     // full frame, start ignored mid-frame
    run_frame(4'd15, 100);
    @(negedge clk);

    din = '1;
    run_frame(4'd2, -1);
    @(negedge clk);

    for (int i = 0; i < 4; i++) begin  // back-to-back frames
      rand_din();
      run_frame(4'($urandom_range(1, 15)), (i == 1) ? 7 : -1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule